// File: doc/BRIEF.md
# Masked Interrupt Register Bank

This block is a bank of 32-bit words for one peripheral unit, reached through a plain address, write-enable, write-data and read-data port. Most words are ordinary storage. Four word addresses, each set by a parameter, form an interrupt controller:

- a raw pending word that collects interrupt bits;
- an acknowledge word whose write data clears pending bits;
- an enable mask;
- a live view of the pending bits that are enabled.

A side port can also raise pending bits in any cycle.

The block drives one level-sensitive interrupt line. The line is high whenever some enabled bit is pending. The line is held in a two-state machine: `LINE_LOW` and `LINE_HIGH`. The machine takes the transition `RISE` (`LINE_LOW` to `LINE_HIGH`) when the next pending and enable values overlap. It takes the transition `FALL` (`LINE_HIGH` to `LINE_LOW`) when they no longer overlap. Each transition also produces a one-cycle change pulse, together with a bit that gives the new line level. Both appear in the cycle after the write that caused them.

Read data is combinational from the current address. An address at or beyond the word count reads as zero, and writes to it are discarded.

Top module: `irq_regbank`

## Requirements
- R1: While reset is active, and in the first cycle after it, every address reads zero. In that state `irq`, `irq_chg` and `irq_chg_level` are low.
- R2: A write to `RAW_ADDR` (default 0) ORs the write data into the pending word. Bits that are 0 in the data keep their value.
- R3: A write to `CLR_ADDR` (default 1) clears each pending bit that is 1 in the write data. All other pending bits keep their value.
- R4: When `set_en` is high, `set_bits` is ORed into the pending word. If a clear write in the same cycle names the same bit, the clear wins.
- R5: A read of `STAT_ADDR` (default 3) returns the pending word ANDed with the mask word, taken from the current register values.
- R6: A write to `STAT_ADDR` changes no register: the pending word, the mask and all storage words keep their values.
- R7: A write to `MASK_ADDR` (default 2) stores the data in the mask. Reads of `MASK_ADDR` and `RAW_ADDR` return the stored words.
- R8: `irq` is 1 exactly when pending AND mask is nonzero. After any write, `irq` reflects the new values from the next cycle on.
- R9: `irq_chg` is high for one cycle, in the cycle after an update that toggles `irq`, and `irq_chg_level` then equals the new `irq`. Updates that leave `irq` unchanged give no pulse. This holds whether the update comes from a mask write or from a pending-word update.
- R10: Every other in-range address is read/write storage. The `CLR_ADDR` word is never written by a clear write, so it always reads zero.
- R11: A write to an address at or beyond `NUM_REGS` (default 16) changes nothing, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| set_en | input | 1 | Side-port strobe that raises pending bits |
| set_bits | input | DATA_W (32) | Bits to raise in the pending word |
| irq | output | 1 | Level interrupt line |
| irq_chg | output | 1 | One-cycle pulse when `irq` toggles |
| irq_chg_level | output | 1 | New level of `irq` while `irq_chg` is high |

## Verification
The hardest case to reach from the ports is a toggle that neither raises nor clears a pending bit. One example is a mask write that uncovers pending bits that were already set. Another is a side-port set in the same cycle as a clear of the same bit, where only the clear takes effect.

Directed sequences set up pending bits with the mask at zero, and then open and close the mask. They also collide a set and a clear on the same bit. Long random runs draw addresses mostly from the four special words, so mask and pending overlaps come and go often. A behavioural model predicts every read, the line and the pulse.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_t;

endpackage

// File: rtl/irq_mask_core.sv
module irq_mask_core
    import irq_regbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_raw,
    input  logic              wr_clr,
    input  logic              wr_mask,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_en,
    input  logic [DATA_W-1:0] set_bits,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq,
    output logic              irq_chg,
    output logic              irq_chg_level
);

    localparam logic [DATA_W-1:0] ZERO_W = '0;

    line_state_t       state_q, state_n;
    logic [DATA_W-1:0] raw_n, mask_n, set_term, or_term, clr_term;

    // Next pending and mask values; a clear overrides any set in the same cycle.
    always_comb begin
        set_term = set_en ? set_bits : ZERO_W;
        or_term  = wr_raw ? wdata : ZERO_W;
        clr_term = wr_clr ? wdata : ZERO_W;
        raw_n    = (raw_q | set_term | or_term) & ~clr_term;
        mask_n   = wr_mask ? wdata : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= raw_n;
            mask_q <= mask_n;
        end
    end

    // Line state machine: RISE and FALL are taken from the next overlap.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LINE_LOW:  if ((raw_n & mask_n) != ZERO_W) state_n = LINE_HIGH;
            LINE_HIGH: if ((raw_n & mask_n) == ZERO_W) state_n = LINE_LOW;
            default:   state_n = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_n;
    end

    // Output process: change pulse and its level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_chg       <= 1'b0;
            irq_chg_level <= 1'b0;
        end else begin
            irq_chg       <= (state_n != state_q);
            irq_chg_level <= (state_n == LINE_HIGH);
        end
    end

    assign irq = (state_q == LINE_HIGH);

    // R8: line agrees with the stored words
    a_r8_line_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_q & mask_q) != ZERO_W));

    // R2: written bits end up set
    a_r2_or_in: assert property (@(posedge clk) disable iff (!rst_n)
        wr_raw && !wr_clr |=> (raw_q & $past(wdata)) == $past(wdata));

    // R3: cleared bits end up zero, even against a side set (R4)
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (raw_q & $past(wdata)) == ZERO_W);

    // R6: status write with nothing else active leaves state alone
    a_r6_stat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && !set_en |=> $stable(raw_q) && $stable(mask_q));

    // R9: pulse only on a toggle, and every toggle pulses
    a_r9_pulse_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_chg |-> (irq != $past(irq)) && (irq_chg_level == irq));
    a_r9_toggle_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != $past(irq)) |-> irq_chg);

endmodule

// File: rtl/irq_gp_store.sv
module irq_gp_store #(
    parameter int DATA_W    = 32,
    parameter int NUM_REGS  = 16,
    parameter int ADDR_W    = 8,
    parameter int RAW_ADDR  = 0,
    parameter int CLR_ADDR  = 1,
    parameter int MASK_ADDR = 2,
    parameter int STAT_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        if (i == RAW_ADDR || i == CLR_ADDR || i == MASK_ADDR || i == STAT_ADDR) begin : g_special
            // Special words have no storage here; the clear word reads zero.
            assign words[i] = '0;
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  words[i] <= '0;
                else if (wr_en && addr == ADDR_W'(i))        words[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) rd_word = words[i];
        end
    end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank #(
    parameter int DATA_W    = 32,
    parameter int NUM_REGS  = 16,
    parameter int ADDR_W    = 8,
    parameter int RAW_ADDR  = 0,
    parameter int CLR_ADDR  = 1,
    parameter int MASK_ADDR = 2,
    parameter int STAT_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              set_en,
    input  logic [DATA_W-1:0] set_bits,
    output logic              irq,
    output logic              irq_chg,
    output logic              irq_chg_level
);

    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_ADDR);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(NUM_REGS);

    initial begin
        a_cfg_addrs: assert (RAW_ADDR != CLR_ADDR && RAW_ADDR != MASK_ADDR &&
                             RAW_ADDR != STAT_ADDR && CLR_ADDR != MASK_ADDR &&
                             CLR_ADDR != STAT_ADDR && MASK_ADDR != STAT_ADDR &&
                             RAW_ADDR < NUM_REGS && CLR_ADDR < NUM_REGS &&
                             MASK_ADDR < NUM_REGS && STAT_ADDR < NUM_REGS);
    end

    logic              in_range;
    logic              hit_raw, hit_clr, hit_mask, hit_stat;
    logic [DATA_W-1:0] raw_q, mask_q, gp_word;

    assign in_range = (addr < A_END);
    assign hit_raw  = (addr == A_RAW);
    assign hit_clr  = (addr == A_CLR);
    assign hit_mask = (addr == A_MASK);
    assign hit_stat = (addr == A_STAT);

    irq_mask_core #(.DATA_W(DATA_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_raw        (wr_en && hit_raw),
        .wr_clr        (wr_en && hit_clr),
        .wr_mask       (wr_en && hit_mask),
        .wr_stat       (wr_en && hit_stat),
        .wdata         (wdata),
        .set_en        (set_en),
        .set_bits      (set_bits),
        .raw_q         (raw_q),
        .mask_q        (mask_q),
        .irq           (irq),
        .irq_chg       (irq_chg),
        .irq_chg_level (irq_chg_level)
    );

    irq_gp_store #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
        .RAW_ADDR(RAW_ADDR), .CLR_ADDR(CLR_ADDR),
        .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && in_range),
        .addr    (addr),
        .wdata   (wdata),
        .rd_word (gp_word)
    );

    always_comb begin
        if (!in_range)     rdata = '0;
        else if (hit_raw)  rdata = raw_q;
        else if (hit_mask) rdata = mask_q;
        else if (hit_stat) rdata = raw_q & mask_q;
        else               rdata = gp_word;
    end

    // R11: reads beyond the bank return zero
    a_r11_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> rdata == '0);

    // R5: status read is the overlap of the two stored words
    a_r5_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
        hit_stat |-> rdata == (raw_q & mask_q));

endmodule

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        set_en = 1'b0;
    logic [31:0] set_bits = '0;
    logic        irq, irq_chg, irq_chg_level;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state
    logic [31:0] m_word [NREG];
    logic [31:0] m_raw = '0, m_mask = '0;
    logic        m_chg = 1'b0, m_lvl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_regbank u_irq_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .set_en(set_en), .set_bits(set_bits), .irq(irq),
        .irq_chg(irq_chg), .irq_chg_level(irq_chg_level)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a >= NREG)  return 32'h0;
        if (a == 8'd0)  return m_raw;
        if (a == 8'd2)  return m_mask;
        if (a == 8'd3)  return m_raw & m_mask;
        if (a == 8'd1)  return 32'h0;
        return m_word[a[3:0]];
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a >= NREG) return "R11";
        if (a == 8'd0) return "R2";
        if (a == 8'd2) return "R7";
        if (a == 8'd3) return "R5";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(rd_tag(addr), rdata, m_read(addr));
        check("R8", {31'b0, irq}, {31'b0, ((m_raw & m_mask) != 0)});
        check("R9", {31'b0, irq_chg}, {31'b0, m_chg});
        if (m_chg) check("R9", {31'b0, irq_chg_level}, {31'b0, m_lvl});
    endtask

    // One cycle: drive after the falling edge, compare, then advance the model at the rising edge.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic se, input logic [31:0] sb);
        logic old_irq, new_irq;
        logic [31:0] nraw;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; set_en = se; set_bits = sb;
        #1;
        compare_all();
        @(posedge clk);
        old_irq = (m_raw & m_mask) != 0;
        nraw = m_raw | (se ? sb : 32'h0) | ((w && a == 8'd0) ? d : 32'h0);
        if (w && a == 8'd1) nraw = nraw & ~d;
        m_raw = nraw;
        if (w && a == 8'd2) m_mask = d;
        if (w && a < NREG && a > 8'd3) m_word[a[3:0]] = d;
        new_irq = (m_raw & m_mask) != 0;
        m_chg = (old_irq != new_irq);
        m_lvl = new_irq;
    endtask

    task automatic rd(input logic [7:0] a);
        step(1'b0, a, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) m_word[i] = '0;
        // R1: reset state
        repeat (2) @(negedge clk);
        for (int i = 0; i < NREG; i++) begin
            addr = 8'(i);
            #1;
            check("R1", rdata, 32'h0);
        end
        check("R1", {29'b0, irq, irq_chg, irq_chg_level}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'd0);  // R1: first cycle after reset
        rd(8'd3);

        // R10: plain storage
        step(1, 8'd5, 32'hA5A5_0001, 0, 0);
        step(1, 8'd15, 32'h1234_5678, 0, 0);
        rd(8'd5); rd(8'd15); rd(8'd4);
        // R11: out of range
        step(1, 8'd16, 32'hFFFF_FFFF, 0, 0);
        step(1, 8'd200, 32'hDEAD_BEEF, 0, 0);
        rd(8'd16); rd(8'd200); rd(8'd0); rd(8'd5);

        // R2: OR-in with mask closed, line stays low
        step(1, 8'd0, 32'h0000_00F0, 0, 0);
        step(1, 8'd0, 32'h0000_0003, 0, 0);
        rd(8'd0);
        // R9: mask write uncovers pending bits, raises the line
        step(1, 8'd2, 32'h0000_0010, 0, 0);
        rd(8'd3);
        step(1, 8'd2, 32'h0000_0030, 0, 0);  // R9: no toggle, no pulse
        step(1, 8'd2, 32'h0000_0100, 0, 0);  // R9: mask closes, line falls
        rd(8'd3);
        // R6: write to status address ignored
        step(1, 8'd2, 32'h0000_00FF, 0, 0);
        step(1, 8'd3, 32'h0000_0000, 0, 0);
        rd(8'd0); rd(8'd2); rd(8'd3);
        // R3: clear some bits, line stays high, then all, line falls
        step(1, 8'd1, 32'h0000_00E0, 0, 0);
        rd(8'd0); rd(8'd1);
        step(1, 8'd1, 32'hFFFF_FFFF, 0, 0);
        rd(8'd0);
        // R4: side set raises, collision with clear loses
        step(0, 8'd0, 32'h0, 1, 32'h0000_0004);
        rd(8'd0);
        step(1, 8'd1, 32'h0000_0004, 1, 32'h0000_000C);
        rd(8'd0); rd(8'd3);

        // Random traffic concentrated on the special words
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a;
            int r;
            r = $urandom_range(0, 9);
            if (r < 7)      a = 8'($urandom_range(0, 3));
            else if (r < 9) a = 8'($urandom_range(4, 15));
            else            a = 8'($urandom_range(16, 255));
            step(1'($urandom_range(0, 1)), a, $urandom & $urandom,
                 1'($urandom_range(0, 3) == 0), 32'h1 << $urandom_range(0, 31));
        end
        rd(8'd0);
        done = 1;
        report();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                report();
            end
        end
    end

endmodule